// File: doc/BRIEF.md
# Branch Resolution and Writeback Stage

This block holds the two ends of branch handling in a small in-order pipeline. On the execute side, a combinational evaluator turns a branch, jump or compare into one result word. A conditional branch yields a target address wrapped to the instruction address space when its condition flag is set. When the flag is clear it yields the all-ones word (-1), which means "not taken". A compare yields an updated flag word. The flags are single bits of the word held in general register 3, which the pipeline feeds in on `ex_flags`.

On the writeback side, the block holds a small in-order reservation queue of destination register indices. Decode pushes one index per issued result-producing instruction. When an instruction retires, the block does one of two things:

- It pops the oldest index and drives the register-file write port, choosing the scalar or vector bank.
- It resolves a jump: it loads the program counter, writes the link register for a jump-and-link, clears the queue and tells every upstream stage to turn its instruction into a NOP.

Two misuse cases set a sticky error flag: a write that finds the queue empty, and a destination index outside both banks.

Top module: `brwb_top`

## Requirements
- R1: Conditional branch ops are encoded on `ex_op` as 0 (equal, flag bit 1), 1 (greater, flag bit 0), 2 (underflow, flag bit 2) and 3 (overflow, flag bit 3). When the selected bit of `ex_flags` is 1, `ex_value` is ((`ex_pc` + `ex_b`) mod 2^ADDR_W), zero-extended. When the bit is 0, `ex_value` is all ones (-1).
- R2: Compare (`ex_op` 6) returns `ex_flags` with bit 0 set to (signed `ex_a` > signed `ex_b`) and bit 1 set to (`ex_a` == `ex_b`). All other bits pass through unchanged.
- R3: `ex_op` 4 returns the zero-extended `ex_pc` plus `ex_b`, with no wrap. `ex_op` 5 returns `ex_a` + `ex_b`. `ex_op` 7 returns `ex_a`.
- R4: A retiring instruction with `wb_op` 2 (NOP) or `wb_kind` 3 (invalid) causes no register write, no pop, no pc load and no squash.
- R5: A retiring instruction of `wb_kind` 0 or 1 whose `wb_op` is not 1 (store) pops the oldest queued index and writes `wb_result` there in the same cycle. A store pops nothing and writes nothing. Queued indices are consumed in push order.
- R6: A popped index below 16 writes scalar bank 0 (`rf_bank`=0) at that index. An index from 16 to 23 writes vector bank 1 at (index - 16).
- R7: A retiring `wb_kind` 2 instruction is a taken jump only when `wb_result` is greater than zero as a signed value. In that case `pc_load` is 1 and `pc_value` is the low ADDR_W bits of `wb_result`, in the same cycle. A zero or negative result does nothing.
- R8: A taken jump with `wb_op` 3 (link) also writes `cur_pc` + 1 to scalar register 1 in the same cycle. Other taken jumps write no register.
- R9: A taken jump raises `squash` in the same cycle and empties the queue. A push in that same cycle is dropped.
- R10: `err` goes to 1 on the cycle after a write finds the queue empty, or pops an index of 24 or more. Neither case writes a register. `err` then stays 1 until reset.
- R11: After reset the queue is empty and `err` is 0. With no instruction retiring, `rf_we`, `pc_load`, `squash` and `q_pop` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ex_op | input | 3 | Execute-side operation code |
| ex_a | input | DATA_W | First operand |
| ex_b | input | DATA_W | Second operand or offset |
| ex_pc | input | ADDR_W | Address of the executing instruction |
| ex_flags | input | DATA_W | Contents of general register 3 |
| ex_value | output | DATA_W | Evaluated target, flag word or sum |
| rsv_push | input | 1 | Push a destination index |
| rsv_idx | input | IDX_W | Destination index to push |
| wb_valid | input | 1 | An instruction retires this cycle |
| wb_op | input | 2 | 0 plain, 1 store, 2 NOP, 3 link jump |
| wb_kind | input | 2 | 0 register, 1 immediate, 2 jump, 3 invalid |
| wb_result | input | DATA_W | Result word or jump target |
| cur_pc | input | ADDR_W | Current program counter |
| rf_we | output | 1 | Register write enable |
| rf_bank | output | 1 | 0 scalar, 1 vector |
| rf_addr | output | IDX_W | Register index within bank |
| rf_data | output | DATA_W | Write data |
| pc_load | output | 1 | Load program counter |
| pc_value | output | ADDR_W | New program counter |
| squash | output | 1 | Turn upstream instructions into NOPs |
| q_pop | output | 1 | Oldest reservation consumed |
| err | output | 1 | Sticky misuse flag |

## Verification
The bench targets several corner cases:

- A branch target that wraps past the top of the address space. A design without the modulo would return an out-of-range address.
- A jump whose result is zero or negative. A design that treated any non-(-1) value as taken would redirect on a zero target.
- A link jump issued in the same cycle as a push. A design without flush priority would leave a stale reservation behind, and a later write would go to the wrong register instead of flagging the empty queue.
- NOPs, invalid instructions and stores issued between queued writes. A design that popped on these would shift every later write one register off.
- Vector-bank and out-of-range indices. These expose an off-by-bank address or a missing error.

// File: rtl/brwb_pkg.sv
package brwb_pkg;
  typedef enum logic [2:0] {
    XOP_BEQ  = 3'd0,
    XOP_BGT  = 3'd1,
    XOP_BUF  = 3'd2,
    XOP_BOF  = 3'd3,
    XOP_JREL = 3'd4,
    XOP_JABS = 3'd5,
    XOP_CMP  = 3'd6,
    XOP_PASS = 3'd7
  } xop_e;

  typedef enum logic [1:0] {
    WOP_ALU   = 2'd0,
    WOP_STORE = 2'd1,
    WOP_NOP   = 2'd2,
    WOP_LINK  = 2'd3
  } wop_e;

  typedef enum logic [1:0] {
    KIND_R   = 2'd0,
    KIND_I   = 2'd1,
    KIND_J   = 2'd2,
    KIND_INV = 2'd3
  } kind_e;

  localparam int FLAG_GT = 0;
  localparam int FLAG_EQ = 1;
  localparam int FLAG_UF = 2;
  localparam int FLAG_OF = 3;
  localparam int LINK_REG = 1;
endpackage

// File: rtl/brwb_branch_eval.sv
module brwb_branch_eval
  import brwb_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 10
) (
  input  logic [2:0]        op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [ADDR_W-1:0] pc,
  input  logic [DATA_W-1:0] flags,
  output logic [DATA_W-1:0] value
);
  localparam logic [DATA_W-1:0] NOT_TAKEN = '1;

  function automatic logic [DATA_W-1:0] wrap_target(logic [ADDR_W-1:0] base,
                                                    logic [DATA_W-1:0] off);
    logic [ADDR_W-1:0] sum;
    sum = base + off[ADDR_W-1:0];
    return DATA_W'(sum);
  endfunction

  function automatic logic [DATA_W-1:0] cmp_flags(logic [DATA_W-1:0] f,
                                                  logic [DATA_W-1:0] x,
                                                  logic [DATA_W-1:0] y);
    logic [DATA_W-1:0] r;
    r = f;
    r[FLAG_GT] = $signed(x) > $signed(y);
    r[FLAG_EQ] = (x == y);
    return r;
  endfunction

  logic flag_sel;

  always_comb begin
    unique case (xop_e'(op))
      XOP_BEQ: flag_sel = flags[FLAG_EQ];
      XOP_BGT: flag_sel = flags[FLAG_GT];
      XOP_BUF: flag_sel = flags[FLAG_UF];
      XOP_BOF: flag_sel = flags[FLAG_OF];
      default: flag_sel = 1'b0;
    endcase
  end

  always_comb begin
    unique case (xop_e'(op))
      XOP_BEQ, XOP_BGT, XOP_BUF, XOP_BOF:
        value = flag_sel ? wrap_target(pc, b) : NOT_TAKEN;
      XOP_JREL: value = DATA_W'(pc) + b;
      XOP_JABS: value = a + b;
      XOP_CMP:  value = cmp_flags(flags, a, b);
      default:  value = a;
    endcase
  end
endmodule

// File: rtl/brwb_resq.sv
module brwb_resq #(
  parameter int IDX_W = 5,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [IDX_W-1:0] push_idx,
  input  logic             pop,
  input  logic             flush,
  output logic [IDX_W-1:0] front,
  output logic             empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [IDX_W-1:0] slots [DEPTH];
  logic [PTR_W-1:0] rd_ptr, wr_ptr;
  logic [CNT_W-1:0] cnt;
  logic             pop_ok, push_ok;

  assign empty   = (cnt == '0);
  assign front   = slots[rd_ptr];
  assign pop_ok  = pop && !empty && !flush;
  assign push_ok = push && !flush && ((cnt < CNT_W'(DEPTH)) || pop_ok);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else if (flush) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (pop_ok) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      if (push_ok) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      cnt <= cnt + CNT_W'(push_ok) - CNT_W'(pop_ok);
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) slots[wr_ptr] <= push_idx;
  end

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty); // R9
endmodule

// File: rtl/brwb_wb.sv
module brwb_wb
  import brwb_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 10,
  parameter int IDX_W   = 5,
  parameter int GPR_NUM = 16,
  parameter int VEC_NUM = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic [1:0]        op,
  input  logic [1:0]        kind,
  input  logic [DATA_W-1:0] result,
  input  logic [ADDR_W-1:0] cur_pc,
  input  logic [IDX_W-1:0]  q_front,
  input  logic              q_empty,
  output logic              want_write,
  output logic              take_jump,
  output logic              bad_idx,
  output logic              rf_we,
  output logic              rf_bank,
  output logic [IDX_W-1:0]  rf_addr,
  output logic [DATA_W-1:0] rf_data,
  output logic              pc_load,
  output logic [ADDR_W-1:0] pc_value,
  output logic              q_pop
);
  localparam int REG_TOTAL = GPR_NUM + VEC_NUM;

  logic live, is_link, in_vec;

  assign live       = valid && (wop_e'(op) != WOP_NOP) && (kind_e'(kind) != KIND_INV);
  assign want_write = live && ((kind_e'(kind) == KIND_R) || (kind_e'(kind) == KIND_I))
                      && (wop_e'(op) != WOP_STORE);
  assign take_jump  = live && (kind_e'(kind) == KIND_J) && ($signed(result) > 0);
  assign is_link    = take_jump && (wop_e'(op) == WOP_LINK);
  assign bad_idx    = want_write && !q_empty && (int'(q_front) >= REG_TOTAL);
  assign in_vec     = int'(q_front) >= GPR_NUM;
  assign q_pop      = want_write && !q_empty;

  always_comb begin
    rf_we   = 1'b0;
    rf_bank = 1'b0;
    rf_addr = '0;
    rf_data = '0;
    if (is_link) begin
      rf_we   = 1'b1;
      rf_addr = IDX_W'(LINK_REG);
      rf_data = DATA_W'(cur_pc) + 1'b1;
    end else if (q_pop && !bad_idx) begin
      rf_we   = 1'b1;
      rf_bank = in_vec;
      rf_addr = in_vec ? q_front - IDX_W'(GPR_NUM) : q_front;
      rf_data = result;
    end
  end

  assign pc_load  = take_jump;
  assign pc_value = result[ADDR_W-1:0];

  AST_NOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && wop_e'(op) == WOP_NOP) |-> (!rf_we && !pc_load && !q_pop)); // R4
  AST_LINK_ONLY_ON_LINKOP: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load && rf_we) |-> (wop_e'(op) == WOP_LINK && rf_addr == IDX_W'(LINK_REG) && !rf_bank)); // R8
endmodule

// File: rtl/brwb_top.sv
module brwb_top
  import brwb_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 10,
  parameter int IDX_W   = 5,
  parameter int GPR_NUM = 16,
  parameter int VEC_NUM = 8,
  parameter int Q_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        ex_op,
  input  logic [DATA_W-1:0] ex_a,
  input  logic [DATA_W-1:0] ex_b,
  input  logic [ADDR_W-1:0] ex_pc,
  input  logic [DATA_W-1:0] ex_flags,
  output logic [DATA_W-1:0] ex_value,
  input  logic              rsv_push,
  input  logic [IDX_W-1:0]  rsv_idx,
  input  logic              wb_valid,
  input  logic [1:0]        wb_op,
  input  logic [1:0]        wb_kind,
  input  logic [DATA_W-1:0] wb_result,
  input  logic [ADDR_W-1:0] cur_pc,
  output logic              rf_we,
  output logic              rf_bank,
  output logic [IDX_W-1:0]  rf_addr,
  output logic [DATA_W-1:0] rf_data,
  output logic              pc_load,
  output logic [ADDR_W-1:0] pc_value,
  output logic              squash,
  output logic              q_pop,
  output logic              err
);
  logic [IDX_W-1:0] q_front;
  logic q_empty, want_write, take_jump, bad_idx, underflow, err_q;

  brwb_branch_eval #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_eval (
    .op(ex_op), .a(ex_a), .b(ex_b), .pc(ex_pc), .flags(ex_flags), .value(ex_value)
  );

  brwb_resq #(.IDX_W(IDX_W), .DEPTH(Q_DEPTH)) u_resq (
    .clk(clk), .rst_n(rst_n), .push(rsv_push), .push_idx(rsv_idx),
    .pop(q_pop), .flush(take_jump), .front(q_front), .empty(q_empty)
  );

  brwb_wb #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W),
            .GPR_NUM(GPR_NUM), .VEC_NUM(VEC_NUM)) u_wb (
    .clk(clk), .rst_n(rst_n), .valid(wb_valid), .op(wb_op), .kind(wb_kind),
    .result(wb_result), .cur_pc(cur_pc), .q_front(q_front), .q_empty(q_empty),
    .want_write(want_write), .take_jump(take_jump), .bad_idx(bad_idx),
    .rf_we(rf_we), .rf_bank(rf_bank), .rf_addr(rf_addr), .rf_data(rf_data),
    .pc_load(pc_load), .pc_value(pc_value), .q_pop(q_pop)
  );

  assign underflow = want_write && q_empty;
  assign squash    = take_jump;

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else if (underflow || bad_idx) err_q <= 1'b1;
  end
  assign err = err_q;

  AST_EMPTY_POP_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> err); // R10
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err); // R10
  AST_NO_WRITE_ON_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow && !take_jump) |-> !rf_we); // R10
endmodule

// File: tb/brwb_top_bench.sv
module brwb_top_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0]  ex_op = '0;
  logic [15:0] ex_a = '0, ex_b = '0, ex_flags = '0;
  logic [9:0]  ex_pc = '0;
  logic [15:0] ex_value;
  logic        rsv_push = 1'b0;
  logic [4:0]  rsv_idx = '0;
  logic        wb_valid = 1'b0;
  logic [1:0]  wb_op = '0, wb_kind = '0;
  logic [15:0] wb_result = '0;
  logic [9:0]  cur_pc = '0;
  logic        rf_we, rf_bank, pc_load, squash, q_pop, err;
  logic [4:0]  rf_addr;
  logic [15:0] rf_data;
  logic [9:0]  pc_value;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [4:0] mq [4];
  int  mcnt = 0;
  bit  merr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  brwb_top u_brwb_top (
    .clk(clk), .rst_n(rst_n), .ex_op(ex_op), .ex_a(ex_a), .ex_b(ex_b),
    .ex_pc(ex_pc), .ex_flags(ex_flags), .ex_value(ex_value),
    .rsv_push(rsv_push), .rsv_idx(rsv_idx), .wb_valid(wb_valid),
    .wb_op(wb_op), .wb_kind(wb_kind), .wb_result(wb_result), .cur_pc(cur_pc),
    .rf_we(rf_we), .rf_bank(rf_bank), .rf_addr(rf_addr), .rf_data(rf_data),
    .pc_load(pc_load), .pc_value(pc_value), .squash(squash), .q_pop(q_pop),
    .err(err)
  );

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] f_ex(logic [2:0] op, logic [15:0] a, logic [15:0] b,
                                       logic [9:0] pc, logic [15:0] fl);
    int t;
    int bit_no;
    logic [15:0] r;
    if (op <= 3) begin
      bit_no = (op == 0) ? 1 : (op == 1) ? 0 : int'(op);
      if (!fl[bit_no]) return 16'hFFFF;
      t = ((int'(pc) + int'($signed(b))) % 1024 + 1024) % 1024;
      return 16'(t);
    end
    if (op == 4) return 16'(int'(pc) + int'(b));
    if (op == 5) return 16'(int'(a) + int'(b));
    if (op == 6) begin
      r = fl;
      r[0] = (int'($signed(a)) > int'($signed(b)));
      r[1] = (a == b);
      return r;
    end
    return a;
  endfunction

  task automatic model_reset();
    mcnt = 0;
    merr = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    rsv_push = 0; wb_valid = 0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  task automatic step(bit push, logic [4:0] pidx, bit v, logic [1:0] op,
                      logic [1:0] kind, logic [15:0] res, logic [9:0] pc,
                      logic [2:0] xop, logic [15:0] a, logic [15:0] b, logic [15:0] fl);
    bit wants, jmp, link, pop_e, we_e, bank_e;
    logic [4:0] fr, addr_e;
    logic [15:0] data_e, xv;
    @(negedge clk);
    rsv_push = push; rsv_idx = pidx; wb_valid = v; wb_op = op; wb_kind = kind;
    wb_result = res; cur_pc = pc; ex_op = xop; ex_a = a; ex_b = b; ex_flags = fl;
    ex_pc = pc ^ 10'h155;
    #1;
    xv = f_ex(xop, a, b, ex_pc, fl);
    chk(ex_value == xv, (xop <= 3) ? "R1 ex_value" : (xop == 6) ? "R2 ex_value" : "R3 ex_value",
        ex_value, xv);
    wants = v && op != 2 && kind != 3 && kind <= 1 && op != 1;
    jmp   = v && op != 2 && kind == 2 && $signed(res) > 0;
    link  = jmp && op == 3;
    fr    = mq[0];
    pop_e = wants && mcnt > 0;
    we_e  = link || (pop_e && fr < 24);
    bank_e = 0; addr_e = 0; data_e = 0;
    if (link) begin addr_e = 1; data_e = 16'(pc) + 16'd1; end
    else if (we_e) begin bank_e = fr >= 16; addr_e = (fr >= 16) ? fr - 5'd16 : fr; data_e = res; end
    chk(err == merr, "R10 err", err, merr);
    chk(q_pop == pop_e, "R5 q_pop", q_pop, pop_e);
    chk(rf_we == we_e, "R4/R5/R8/R10 rf_we", rf_we, we_e);
    if (we_e) begin
      chk(rf_bank == bank_e, "R6 rf_bank", rf_bank, bank_e);
      chk(rf_addr == addr_e, "R6/R8 rf_addr", rf_addr, addr_e);
      chk(rf_data == data_e, "R5/R8 rf_data", rf_data, data_e);
    end
    chk(pc_load == jmp, "R7 pc_load", pc_load, jmp);
    chk(squash == jmp, "R9 squash", squash, jmp);
    if (jmp) chk(pc_value == res[9:0], "R7 pc_value", pc_value, res[9:0]);
    if (wants && (mcnt == 0 || fr >= 24)) merr = 1;
    if (jmp) mcnt = 0;
    else begin
      if (pop_e) begin
        for (int i = 0; i < 3; i++) mq[i] = mq[i+1];
        mcnt--;
      end
      if (push && mcnt < 4) begin mq[mcnt] = pidx; mcnt++; end
    end
  endtask

  task automatic idle_push(logic [4:0] idx);
    step(1, idx, 0, 0, 0, 16'h0, 10'h0, 3'd7, 16'h0, 16'h0, 16'h0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int unsigned seed;
    seed = 32'h5EED1234;
    void'($urandom(seed));
    do_reset();
    // R11: reset state, nothing retiring
    #1;
    chk(err == 0, "R11 err", err, 0);
    chk(rf_we == 0 && pc_load == 0 && squash == 0 && q_pop == 0, "R11 outputs", rf_we, 0);
    // R1: wrap past the top of the address space, flag set and clear
    step(0, 0, 0, 0, 0, 0, 10'h3FF ^ 10'h155, 3'd1, 16'h0, 16'h0002, 16'h0001);
    step(0, 0, 0, 0, 0, 0, 10'h010, 3'd0, 16'h0, 16'hFFFE, 16'h0001);
    step(0, 0, 0, 0, 0, 0, 10'h010, 3'd3, 16'h0, 16'h0004, 16'h0008);
    // R2 / R3
    step(0, 0, 0, 0, 0, 0, 10'h020, 3'd6, 16'h8000, 16'h0001, 16'hFF00);
    step(0, 0, 0, 0, 0, 0, 10'h020, 3'd4, 16'h0, 16'hFFF0, 16'h0);
    step(0, 0, 0, 0, 0, 0, 10'h020, 3'd5, 16'h1234, 16'h1111, 16'h0);
    // R5 / R6: ordered pops, store in between, vector bank
    idle_push(5'd5);
    idle_push(5'd20);
    step(0, 0, 1, 0, 0, 16'h1234, 0, 3'd7, 0, 0, 0);
    step(0, 0, 1, 1, 1, 16'h9999, 0, 3'd7, 0, 0, 0);
    step(0, 0, 1, 0, 1, 16'hBEEF, 0, 3'd7, 0, 0, 0);
    // R4: NOP and invalid leave the queue alone
    idle_push(5'd7);
    step(0, 0, 1, 2, 0, 16'h1111, 0, 3'd7, 0, 0, 0);
    step(0, 0, 1, 0, 3, 16'h2222, 0, 3'd7, 0, 0, 0);
    step(0, 0, 1, 0, 0, 16'h3333, 0, 3'd7, 0, 0, 0);
    // R7: zero and negative results are not taken; positive is
    step(0, 0, 1, 0, 2, 16'h0000, 0, 3'd7, 0, 0, 0);
    step(0, 0, 1, 0, 2, 16'hFFFB, 0, 3'd7, 0, 0, 0);
    step(0, 0, 1, 0, 2, 16'h0040, 0, 3'd7, 0, 0, 0);
    // R8 / R9: link jump with a same-cycle push, then a write finds the queue empty
    idle_push(5'd3);
    idle_push(5'd9);
    step(1, 5'd11, 1, 3, 2, 16'h0100, 10'h033, 3'd7, 0, 0, 0);
    step(0, 0, 1, 0, 0, 16'h4444, 0, 3'd7, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 3'd7, 0, 0, 0);
    // R10: out-of-range index, sticky after
    do_reset();
    idle_push(5'd30);
    step(0, 0, 1, 0, 0, 16'h5555, 0, 3'd7, 0, 0, 0);
    idle_push(5'd2);
    step(0, 0, 1, 0, 1, 16'h6666, 0, 3'd7, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 3'd7, 0, 0, 0);
    // random traffic
    do_reset();
    for (int n = 0; n < 3000; n++) begin
      bit p, v;
      logic [4:0] idx;
      logic [1:0] op, kind;
      logic [15:0] res;
      p   = ($urandom % 3) != 0;
      idx = ($urandom % 8 == 0) ? 5'(24 + $urandom % 8) : 5'($urandom % 24);
      v   = ($urandom % 2) == 1;
      op  = 2'($urandom % 4);
      kind = ($urandom % 6 == 0) ? 2'd2 : 2'($urandom % 4);
      res = 16'($urandom);
      if (kind == 2 && ($urandom % 3) == 0) res = 16'($urandom % 3);
      step(p, idx, v, op, kind, res, 10'($urandom), 3'($urandom), 16'($urandom),
           ($urandom % 4 == 0) ? 16'($urandom % 4) : 16'($urandom), 16'($urandom));
    end
    finish_run();
  end
endmodule